// File: doc/BRIEF.md
# Dual-Domain Priority Bus Arbiter

This block decides who owns two buses that run side by side. On the internal side three on-chip masters compete: a DMA engine, a data-transfer engine and the CPU. The block returns a one-hot acknowledge, and the acknowledged master drives the bus until it signals that its bus cycle has finished. On the external side the internal domain's request for an off-chip access competes with a request from an external master that wants the bus released. The block returns a one-hot grant. The two decisions are made by separate logic and do not wait on each other.

Ordering is fixed. On the internal side the DMA engine ranks above the data-transfer engine, which ranks above the CPU. On the external side the release request ranks above the internal domain. The internal arbiter also has a fairness mode, selected by an input pin. In this mode the CPU takes every other bus cycle when the two transfer engines keep the bus busy. A one-bit memory of whether the last finished cycle belonged to the CPU drives this mode.

A domain makes a new decision only while its bus is idle, or in the clock cycle where the current owner raises its cycle-done input. The new owner appears on the following rising clock edge.

Top module: `dual_bus_arbiter`

## Requirements
- R1: The reset input `rst_n` is active low and asynchronous. Reset clears every acknowledge and grant and also clears the CPU-turn memory. The first decision after reset in fairness mode therefore gives the bus to a requesting CPU.
- R2: When fairness mode is off, an internal decision goes to the highest requester. Bit 2 of `int_req` (DMA) wins over bit 1 (data transfer), which wins over bit 0 (CPU). `int_ack` uses the same bit positions and changes on the rising edge that ends the deciding cycle.
- R3: In any clock cycle at most one bit of `int_ack` is high and at most one bit of `ext_gnt` is high. A bit only goes high for a master that was requesting in the deciding cycle.
- R4: While an owner holds its bus and that domain's done input is low, the acknowledge or grant does not change. A new higher request or a dropped request has no effect.
- R5: A domain decides while it is idle or when its done input is high. A done input that is high while that domain is idle has no effect. If nothing is requesting at a decision, the domain goes idle on the next edge.
- R6: In fairness mode, the CPU wins a decision whenever it requests and the last finished internal cycle was not the CPU's. The cycle finishing in the deciding clock counts as the last one. If the CPU has just had a cycle, the fixed order applies.
- R7: In fairness mode the DMA engine still wins over the data-transfer engine.
- R8: On the external side, bit 1 of `ext_req` (release request) wins over bit 0 (internal domain's off-chip access). `ext_gnt` uses the same bit positions.
- R9: The two domains are independent. `int_done` and `int_req` never change `ext_gnt`, and `ext_done` and `ext_req` never change `int_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_mode | input | 1 | Fairness mode enable: CPU alternates with the transfer engines |
| int_req | input | 3 | Internal requests: bit 2 DMA, bit 1 data transfer, bit 0 CPU |
| int_done | input | 1 | Current internal owner finishes its bus cycle this clock |
| int_ack | output | 3 | One-hot internal acknowledge, same bit positions as int_req |
| ext_req | input | 2 | External requests: bit 1 release request, bit 0 internal off-chip access |
| ext_done | input | 1 | Current external owner finishes its bus cycle this clock |
| ext_gnt | output | 2 | One-hot external grant, same bit positions as ext_req |

## Verification
The assertions assume that the inputs are synchronous to `clk` and hold known values at each rising edge. They assume nothing about how requests behave over time: a master may drop its request, or a done input may pulse, at any moment. The stimulus therefore changes every input only on the falling edge. It mixes directed sequences with random request vectors and random done pulses, including done pulses while a domain is idle and requests that vanish mid-cycle. Fairness mode is switched on and off during the random phase, so the CPU-turn memory is exercised across mode changes.

// File: rtl/dual_arb_pkg.sv
`timescale 1ns/1ps
package dual_arb_pkg;
  localparam int INT_MASTERS = 3;
  localparam int EXT_MASTERS = 2;
  localparam int IDX_CPU     = 0;
  localparam int IDX_DTE     = 1;
  localparam int IDX_DMA     = 2;
  localparam int IDX_XLOCAL  = 0;
  localparam int IDX_XREL    = 1;

  // CPU takes the turn when fairness is on, it asks, and it did not own the last finished cycle
  function automatic logic cpu_takes_turn(input logic fair_on, input logic cpu_asks,
                                          input logic last_was_cpu);
    return fair_on && cpu_asks && !last_was_cpu;
  endfunction

  // the cycle just ending defines "last"; otherwise the remembered value does
  function automatic logic last_owner_cpu(input logic ending, input logic owner_is_cpu,
                                          input logic remembered);
    return ending ? owner_is_cpu : remembered;
  endfunction
endpackage

// File: rtl/arb_fixed_pick.sv
`timescale 1ns/1ps
module arb_fixed_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  always_comb begin
    logic seen;
    seen = 1'b0;
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && !seen) begin
        pick[i] = 1'b1;
        seen    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_owner_reg.sv
`timescale 1ns/1ps
module arb_owner_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] next_owner,
  input  logic         cycle_done,
  output logic [N-1:0] owner,
  output logic         decide
);
  logic bus_idle;
  assign bus_idle = (owner == '0);
  assign decide   = bus_idle || cycle_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       owner <= '0;
    else if (decide)  owner <= next_owner;
  end

  assert_owner_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));

  assert_hold_mid_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle && !cycle_done) |=> $stable(owner));
endmodule

// File: rtl/arb_int_domain.sv
`timescale 1ns/1ps
module arb_int_domain
  import dual_arb_pkg::*;
#(
  parameter int N           = INT_MASTERS,
  parameter int CPU_POS     = IDX_CPU,
  parameter int DTE_POS     = IDX_DTE,
  parameter int DMA_POS     = IDX_DMA,
  parameter bit FAIR_SUPPORT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fair_on,
  input  logic [N-1:0] req,
  input  logic         done,
  output logic [N-1:0] ack
);
  localparam logic [N-1:0] CPU_MASK = {{(N-1){1'b0}}, 1'b1} << CPU_POS;

  logic [N-1:0] fixed_pick;
  logic [N-1:0] next_owner;
  logic         decide;
  logic         cycle_end;
  logic         last_eff;
  logic         cpu_turn;

  assign cycle_end = done && (ack != '0);

  arb_fixed_pick #(.N(N)) u_pick (
    .req  (req),
    .pick (fixed_pick)
  );

  generate
    if (FAIR_SUPPORT) begin : g_fair
      logic last_cpu_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          last_cpu_q <= 1'b0;
        else if (cycle_end)  last_cpu_q <= ack[CPU_POS];
      end
      assign last_eff = last_owner_cpu(cycle_end, ack[CPU_POS], last_cpu_q);
      assign cpu_turn = cpu_takes_turn(fair_on, req[CPU_POS], last_eff);
    end else begin : g_fixed
      assign last_eff = 1'b1;
      assign cpu_turn = 1'b0;
    end
  endgenerate

  assign next_owner = cpu_turn ? CPU_MASK : fixed_pick;

  arb_owner_reg #(.N(N)) u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_owner (next_owner),
    .cycle_done (done),
    .owner      (ack),
    .decide     (decide)
  );

  assert_fixed_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !fair_on && req[DMA_POS]) |=> ack[DMA_POS]);

  assert_dte_over_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !fair_on && req[DTE_POS] && !req[DMA_POS]) |=> ack[DTE_POS]);

  assert_only_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req != '0) |=> ((ack & $past(req)) != '0));

  assert_idle_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req == '0) |=> (ack == '0));

  assert_cpu_alternates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fair_on && cycle_end && !ack[CPU_POS] && req[CPU_POS]) |=> ack[CPU_POS]);

  assert_cpu_yields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fair_on && cycle_end && ack[CPU_POS] && req[DMA_POS]) |=> ack[DMA_POS]);

  assert_dma_over_dte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req[DMA_POS]) |=> !ack[DTE_POS]);
endmodule

// File: rtl/arb_ext_domain.sv
`timescale 1ns/1ps
module arb_ext_domain
  import dual_arb_pkg::*;
#(
  parameter int N       = EXT_MASTERS,
  parameter int REL_POS = IDX_XREL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         done,
  output logic [N-1:0] gnt
);
  logic [N-1:0] fixed_pick;
  logic         decide;

  arb_fixed_pick #(.N(N)) u_pick (
    .req  (req),
    .pick (fixed_pick)
  );

  arb_owner_reg #(.N(N)) u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_owner (fixed_pick),
    .cycle_done (done),
    .owner      (gnt),
    .decide     (decide)
  );

  assert_release_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req[REL_POS]) |=> gnt[REL_POS]);

  assert_ext_only_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req != '0) |=> ((gnt & $past(req)) != '0));
endmodule

// File: rtl/dual_bus_arbiter.sv
`timescale 1ns/1ps
module dual_bus_arbiter
  import dual_arb_pkg::*;
#(
  parameter int INT_N = INT_MASTERS,
  parameter int EXT_N = EXT_MASTERS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alt_mode,
  input  logic [INT_N-1:0] int_req,
  input  logic             int_done,
  output logic [INT_N-1:0] int_ack,
  input  logic [EXT_N-1:0] ext_req,
  input  logic             ext_done,
  output logic [EXT_N-1:0] ext_gnt
);
  arb_int_domain #(
    .N            (INT_N),
    .CPU_POS      (IDX_CPU),
    .DTE_POS      (IDX_DTE),
    .DMA_POS      (IDX_DMA),
    .FAIR_SUPPORT (1'b1)
  ) u_int (
    .clk     (clk),
    .rst_n   (rst_n),
    .fair_on (alt_mode),
    .req     (int_req),
    .done    (int_done),
    .ack     (int_ack)
  );

  arb_ext_domain #(
    .N       (EXT_N),
    .REL_POS (IDX_XREL)
  ) u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ext_req),
    .done  (ext_done),
    .gnt   (ext_gnt)
  );

  assert_ext_ignores_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_gnt != '0 && !ext_done) |=> $stable(ext_gnt));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (int_ack == '0 && ext_gnt == '0));
endmodule

// File: tb/test_dual_bus_arbiter.sv
`timescale 1ns/1ps
module test_dual_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alt_mode = 1'b0;
  logic [2:0] int_req = '0;
  logic       int_done = 1'b0;
  logic [2:0] int_ack;
  logic [1:0] ext_req = '0;
  logic       ext_done = 1'b0;
  logic [1:0] ext_gnt;

  int checks = 0;
  int fails  = 0;

  logic [2:0] m_int  = '0;
  logic [1:0] m_ext  = '0;
  logic       m_last = 1'b0;

  logic [4:0] q_val[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  dual_bus_arbiter i_dual_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode),
    .int_req(int_req), .int_done(int_done), .int_ack(int_ack),
    .ext_req(ext_req), .ext_done(ext_done), .ext_gnt(ext_gnt)
  );

  function automatic logic [2:0] ref_int(input logic [2:0] r, input logic fair, input logic last_cpu);
    if (fair && r[0] && !last_cpu) return 3'b001;
    if (r[2]) return 3'b100;
    if (r[1]) return 3'b010;
    if (r[0]) return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic [1:0] ref_ext(input logic [1:0] r);
    if (r[1]) return 2'b10;
    if (r[0]) return 2'b01;
    return 2'b00;
  endfunction

  // driver: applies one cycle of stimulus and pushes the expected owners
  task automatic drive(input logic [2:0] ir, input logic id, input logic [1:0] er,
                       input logic ed, input logic fair, input string tag);
    logic le;
    @(negedge clk);
    int_req = ir; int_done = id; ext_req = er; ext_done = ed; alt_mode = fair;
    if (m_int == 3'b000 || id) begin
      le = (id && m_int != 3'b000) ? m_int[0] : m_last;
      if (id && m_int != 3'b000) m_last = m_int[0];
      m_int = ref_int(ir, fair, le);
    end
    if (m_ext == 2'b00 || ed) m_ext = ref_ext(er);
    q_val.push_back({m_int, m_ext});
    q_tag.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; int_req = '0; int_done = 1'b0; ext_req = '0; ext_done = 1'b0;
    m_int = '0; m_ext = '0; m_last = 1'b0;
    @(negedge clk);
    checks++;
    if (int_ack !== 3'b000 || ext_gnt !== 2'b00) begin
      fails++;
      $display("FAIL R1: got %b/%b expected 000/00", int_ack, ext_gnt);
    end
    rst_n = 1'b1;
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      logic [4:0] exp;
      string tg;
      @(posedge clk);
      #2;
      if (q_val.size() != 0) begin
        exp = q_val.pop_front();
        tg  = q_tag.pop_front();
        checks++;
        if ({int_ack, ext_gnt} !== exp) begin
          fails++;
          $display("FAIL %s: got ack=%b gnt=%b expected ack=%b gnt=%b",
                   tg, int_ack, ext_gnt, exp[4:2], exp[1:0]);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R2: fixed order, fairness off
    drive(3'b111, 0, 2'b00, 0, 0, "R2");
    drive(3'b011, 1, 2'b00, 0, 0, "R2");
    drive(3'b001, 1, 2'b00, 0, 0, "R2");
    // R4: hold while done low, higher arrives and own request drops
    drive(3'b100, 0, 2'b00, 0, 0, "R4");
    drive(3'b000, 0, 2'b00, 0, 0, "R4");
    // R5: done with nothing pending -> idle; done while idle is harmless
    drive(3'b000, 1, 2'b00, 0, 0, "R5");
    drive(3'b000, 1, 2'b00, 1, 0, "R5");
    drive(3'b010, 0, 2'b00, 0, 0, "R5");
    drive(3'b010, 1, 2'b00, 0, 0, "R5");
    // R6: fairness, DMA and CPU busy, done every cycle
    for (int k = 0; k < 6; k++) drive(3'b101, 1, 2'b00, 0, 1, "R6");
    // R7: fairness, DMA and DTE without CPU
    for (int k = 0; k < 3; k++) drive(3'b110, 1, 2'b00, 0, 1, "R7");
    drive(3'b000, 1, 2'b00, 0, 1, "R5");
    // R8: release request wins
    drive(3'b000, 0, 2'b11, 0, 0, "R8");
    drive(3'b000, 0, 2'b01, 1, 0, "R8");
    drive(3'b000, 0, 2'b11, 0, 0, "R4");
    drive(3'b000, 0, 2'b00, 1, 0, "R5");
    // R9: independence of the two domains
    drive(3'b010, 0, 2'b01, 0, 0, "R9");
    drive(3'b100, 1, 2'b10, 0, 0, "R9");
    drive(3'b001, 0, 2'b10, 1, 0, "R9");
    drive(3'b001, 1, 2'b01, 0, 0, "R9");
    // R1: CPU memory cleared by reset
    drive(3'b001, 1, 2'b00, 1, 1, "R6");
    drive(3'b001, 1, 2'b00, 0, 1, "R6");
    do_reset();
    drive(3'b101, 0, 2'b00, 0, 1, "R1");
    drive(3'b101, 1, 2'b00, 0, 1, "R1");
    // random phase across both modes
    for (int k = 0; k < 600; k++) begin
      drive(3'($urandom), ($urandom % 3) == 0, 2'($urandom), ($urandom % 3) == 0,
            k >= 300, "R3");
    end
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule